// File: doc/BRIEF.md
# Dual Synthesizer Serial Configuration Loader

This block receives configuration words for a two-channel frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. Bits enter a 23-bit shift register on rising serial-clock edges, most significant bit first. While the load strobe is high, the word in the shift register is decoded and copied into one of four setting latches. The target latch is chosen by the two bits received last. The latches hold the reference divide ratio and the main divider (swallow count plus program count) for channel A and for channel B. The same words also carry the phase-detector polarity, the prescaler-ratio select and the monitor-output select. The latched values drive the synthesizer's counters and output multiplexer directly.

The serial inputs are assumed to be already synchronous to the system clock `clk`. The block samples them on each rising edge of `clk` and finds the serial-clock rising edge by comparing the current level with the level one cycle earlier. A word whose divide value is below the legal minimum of 5 is rejected as a whole, and a sticky error flag is raised. The flag stays set until reset.

Top module: `synth_serial_loader`

## Requirements
- R1: On a `clk` edge where `ser_clk` is high and was low at the previous edge, the shift register moves one place toward its MSB and takes `ser_data` into bit 0. After 23 such edges, the first bit sent sits in bit 22.
- R2: Bits [1:0] of the word select the target latch: 2'b00 = channel-B reference, 2'b01 = channel-B main, 2'b10 = channel-A reference, 2'b11 = channel-A main.
- R3: A reference word carries the divide ratio in bits [15:2], the polarity-reverse flag in bit 16 and the high-band prescaler select in bit 17. All three go to the addressed channel.
- R4: A main word carries the 7-bit swallow count in bits [8:2] and the 11-bit program count in bits [19:9]. A swallow count of 0 is legal.
- R5: Bit 18 of a channel-A reference word (code 2'b10) sets `mon_sel`: 1 selects the phase-comparator monitor and 0 selects lock detect. Bit 18 of a channel-B reference word has no effect.
- R6: Loading is level sensitive. On every `clk` edge while `ser_le` is high, the current shift-register word is decoded and latched. While `ser_le` is low, no latch and no flag changes.
- R7: A load changes only the latch its control code selects. All other latches, including the other channel's latches, keep their values.
- R8: After reset, every latch output, `mon_sel` and `cfg_err` are zero.
- R9: A reference word with a ratio below 5, or a main word with a program count below 5, changes no output except `cfg_err`. That word sets `cfg_err`, and `cfg_err` then stays set until reset.
- R10: The boundary values are accepted: ratio 16383, ratio 5, program count 5 and program count 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (synchronous level) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Level-sensitive load strobe |
| a_ref_div | output | 14 | Channel A reference divide ratio |
| a_swallow | output | 7 | Channel A swallow count |
| a_prog | output | 11 | Channel A program count |
| a_pol_inv | output | 1 | Channel A phase-detector polarity reverse |
| a_hi_presc | output | 1 | Channel A high prescaler ratio select |
| b_ref_div | output | 14 | Channel B reference divide ratio |
| b_swallow | output | 7 | Channel B swallow count |
| b_prog | output | 11 | Channel B program count |
| b_pol_inv | output | 1 | Channel B phase-detector polarity reverse |
| b_hi_presc | output | 1 | Channel B high prescaler ratio select |
| mon_sel | output | 1 | Monitor output select (1 = phase monitor) |
| cfg_err | output | 1 | Sticky out-of-range word flag |

## Verification
A fault in the shift register, such as a lost edge or a wrong shift direction, shows at the outputs only once the load strobe goes high. From that first strobe cycle onward it appears as wrong field values or as a load into the wrong latch. A fault in the decode or validity logic shows one `clk` cycle after the strobe: the wrong channel changes, a field lands in the wrong place, or `cfg_err` takes the wrong value. The bench runs a behavioural model and compares every output on every clock, so any such difference is reported in the cycle it first appears at the ports.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
    localparam int CTRL_W = 2;

    typedef enum logic [CTRL_W-1:0] {
        DST_B_REF  = 2'b00,
        DST_B_MAIN = 2'b01,
        DST_A_REF  = 2'b10,
        DST_A_MAIN = 2'b11
    } dst_e;
endpackage

// File: rtl/ssl_shifter.sv
module ssl_shifter #(
    parameter int WORD_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic              clk_prev;
        logic [WORD_W-1:0] sh;
    } state_t;

    state_t s_d, s_q;
    logic   rise;

    assign rise = ser_clk && !s_q.clk_prev;

    always_comb begin
        s_d          = s_q;
        s_d.clk_prev = ser_clk;
        if (rise) begin
            s_d.sh = {s_q.sh[WORD_W-2:0], ser_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word = s_q.sh;

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && !s_q.clk_prev) |=> (word[0] == $past(ser_data)
                                         && word[WORD_W-1:1] == $past(word[WORD_W-2:0]))); // R1
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_clk && !s_q.clk_prev) |=> $stable(word)); // R1
endmodule

// File: rtl/ssl_decode.sv
module ssl_decode
    import ssl_pkg::*;
#(
    parameter int WORD_W  = 23,
    parameter int REF_W   = 14,
    parameter int SWAL_W  = 7,
    parameter int PROG_W  = 11,
    parameter int MIN_DIV = 5
) (
    input  logic [WORD_W-1:0] word,
    output logic              chan_a,
    output logic              is_main,
    output logic [REF_W-1:0]  ref_val,
    output logic              pol,
    output logic              presc,
    output logic              mon,
    output logic [SWAL_W-1:0] swal,
    output logic [PROG_W-1:0] prog,
    output logic              ok
);
    localparam int REF_LO    = CTRL_W;
    localparam int POL_BIT   = REF_LO + REF_W;
    localparam int PRESC_BIT = POL_BIT + 1;
    localparam int MON_BIT   = PRESC_BIT + 1;
    localparam int SWAL_LO   = CTRL_W;
    localparam int PROG_LO   = SWAL_LO + SWAL_W;

    dst_e dst;

    always_comb begin
        dst     = dst_e'(word[CTRL_W-1:0]);
        chan_a  = (dst == DST_A_REF) || (dst == DST_A_MAIN);
        is_main = (dst == DST_A_MAIN) || (dst == DST_B_MAIN);
        ref_val = word[REF_LO +: REF_W];
        pol     = word[POL_BIT];
        presc   = word[PRESC_BIT];
        mon     = word[MON_BIT] && (dst == DST_A_REF);
        swal    = word[SWAL_LO +: SWAL_W];
        prog    = word[PROG_LO +: PROG_W];
        ok      = is_main ? (int'(prog) >= MIN_DIV) : (int'(ref_val) >= MIN_DIV);
    end
endmodule

// File: rtl/ssl_chan.sv
module ssl_chan #(
    parameter int REF_W   = 14,
    parameter int SWAL_W  = 7,
    parameter int PROG_W  = 11,
    parameter int MIN_DIV = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_ref,
    input  logic              ld_main,
    input  logic [REF_W-1:0]  ref_in,
    input  logic              pol_in,
    input  logic              presc_in,
    input  logic [SWAL_W-1:0] swal_in,
    input  logic [PROG_W-1:0] prog_in,
    output logic [REF_W-1:0]  ref_o,
    output logic              pol_o,
    output logic              presc_o,
    output logic [SWAL_W-1:0] swal_o,
    output logic [PROG_W-1:0] prog_o
);
    typedef struct packed {
        logic [REF_W-1:0]  ref_div;
        logic              pol;
        logic              presc;
        logic [SWAL_W-1:0] swal;
        logic [PROG_W-1:0] prog;
    } chan_t;

    chan_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (ld_ref) begin
            c_d.ref_div = ref_in;
            c_d.pol     = pol_in;
            c_d.presc   = presc_in;
        end
        if (ld_main) begin
            c_d.swal = swal_in;
            c_d.prog = prog_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ref_o   = c_q.ref_div;
    assign pol_o   = c_q.pol;
    assign presc_o = c_q.presc;
    assign swal_o  = c_q.swal;
    assign prog_o  = c_q.prog;

    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_ref || ld_main) |=> $stable({ref_o, pol_o, presc_o, swal_o, prog_o})); // R7
    AST_REF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_o == '0) || (int'(ref_o) >= MIN_DIV)); // R9
    AST_PROG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_o == '0) || (int'(prog_o) >= MIN_DIV)); // R9
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader #(
    parameter int WORD_W  = 23,
    parameter int REF_W   = 14,
    parameter int SWAL_W  = 7,
    parameter int PROG_W  = 11,
    parameter int MIN_DIV = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [REF_W-1:0]  a_ref_div,
    output logic [SWAL_W-1:0] a_swallow,
    output logic [PROG_W-1:0] a_prog,
    output logic              a_pol_inv,
    output logic              a_hi_presc,
    output logic [REF_W-1:0]  b_ref_div,
    output logic [SWAL_W-1:0] b_swallow,
    output logic [PROG_W-1:0] b_prog,
    output logic              b_pol_inv,
    output logic              b_hi_presc,
    output logic              mon_sel,
    output logic              cfg_err
);
    localparam int NCHAN = 2;

    typedef struct packed {
        logic mon;
        logic err;
    } top_t;

    logic [WORD_W-1:0] word;
    logic              chan_a, is_main, pol, presc, mon, ok;
    logic [REF_W-1:0]  ref_val;
    logic [SWAL_W-1:0] swal;
    logic [PROG_W-1:0] prog;

    logic [REF_W-1:0]  ref_arr   [NCHAN];
    logic [SWAL_W-1:0] swal_arr  [NCHAN];
    logic [PROG_W-1:0] prog_arr  [NCHAN];
    logic              pol_arr   [NCHAN];
    logic              presc_arr [NCHAN];

    top_t t_d, t_q;

    ssl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .word(word)
    );

    ssl_decode #(
        .WORD_W(WORD_W), .REF_W(REF_W), .SWAL_W(SWAL_W), .PROG_W(PROG_W), .MIN_DIV(MIN_DIV)
    ) u_dec (
        .word(word), .chan_a(chan_a), .is_main(is_main), .ref_val(ref_val), .pol(pol),
        .presc(presc), .mon(mon), .swal(swal), .prog(prog), .ok(ok)
    );

    // Channel index 0 is channel B (code MSB 0), index 1 is channel A (code MSB 1).
    for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
        logic hit;
        assign hit = ser_le && ok && (chan_a == (ch == 1));

        ssl_chan #(
            .REF_W(REF_W), .SWAL_W(SWAL_W), .PROG_W(PROG_W), .MIN_DIV(MIN_DIV)
        ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .ld_ref(hit && !is_main), .ld_main(hit && is_main),
            .ref_in(ref_val), .pol_in(pol), .presc_in(presc),
            .swal_in(swal), .prog_in(prog),
            .ref_o(ref_arr[ch]), .pol_o(pol_arr[ch]), .presc_o(presc_arr[ch]),
            .swal_o(swal_arr[ch]), .prog_o(prog_arr[ch])
        );
    end

    always_comb begin
        t_d = t_q;
        if (ser_le) begin
            if (!ok) t_d.err = 1'b1;
            else if (chan_a && !is_main) t_d.mon = mon;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign a_ref_div  = ref_arr[1];
    assign a_swallow  = swal_arr[1];
    assign a_prog     = prog_arr[1];
    assign a_pol_inv  = pol_arr[1];
    assign a_hi_presc = presc_arr[1];
    assign b_ref_div  = ref_arr[0];
    assign b_swallow  = swal_arr[0];
    assign b_prog     = prog_arr[0];
    assign b_pol_inv  = pol_arr[0];
    assign b_hi_presc = presc_arr[0];
    assign mon_sel    = t_q.mon;
    assign cfg_err    = t_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R9
    AST_BAD_WORD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_le && !ok) |=> ($stable({a_ref_div, a_swallow, a_prog, a_pol_inv, a_hi_presc,
                                       b_ref_div, b_swallow, b_prog, b_pol_inv, b_hi_presc,
                                       mon_sel}) && cfg_err)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_le |=> $stable({a_ref_div, a_swallow, a_prog, a_pol_inv, a_hi_presc,
                             b_ref_div, b_swallow, b_prog, b_pol_inv, b_hi_presc,
                             mon_sel, cfg_err})); // R6
endmodule

// File: tb/synth_serial_loader_test.sv
module synth_serial_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [13:0] a_ref_div, b_ref_div;
    logic [6:0]  a_swallow, b_swallow;
    logic [10:0] a_prog, b_prog;
    logic a_pol_inv, a_hi_presc, b_pol_inv, b_hi_presc, mon_sel, cfg_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    synth_serial_loader uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .a_ref_div(a_ref_div), .a_swallow(a_swallow), .a_prog(a_prog),
        .a_pol_inv(a_pol_inv), .a_hi_presc(a_hi_presc),
        .b_ref_div(b_ref_div), .b_swallow(b_swallow), .b_prog(b_prog),
        .b_pol_inv(b_pol_inv), .b_hi_presc(b_hi_presc),
        .mon_sel(mon_sel), .cfg_err(cfg_err)
    );

    // Behavioural reference model
    int m_sh, m_prev;
    int m_ref[2], m_swal[2], m_prog[2], m_pol[2], m_presc[2];
    int m_mon, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sh = 0; m_prev = 0; m_mon = 0; m_err = 0;
            for (int c = 0; c < 2; c++) begin
                m_ref[c] = 0; m_swal[c] = 0; m_prog[c] = 0; m_pol[c] = 0; m_presc[c] = 0;
            end
        end else begin
            if (ser_le) begin
                int code, ch, r, s, p;
                code = m_sh % 4;
                ch   = code / 2;
                r    = (m_sh / 4) % 16384;
                s    = (m_sh / 4) % 128;
                p    = (m_sh / 512) % 2048;
                if (code % 2 == 0) begin
                    if (r < 5) m_err = 1;
                    else begin
                        m_ref[ch]   = r;
                        m_pol[ch]   = (m_sh / 65536) % 2;
                        m_presc[ch] = (m_sh / 131072) % 2;
                        if (ch == 1) m_mon = (m_sh / 262144) % 2;
                    end
                end else begin
                    if (p < 5) m_err = 1;
                    else begin
                        m_swal[ch] = s;
                        m_prog[ch] = p;
                    end
                end
            end
            if (ser_clk && m_prev == 0) m_sh = (m_sh * 2 + int'(ser_data)) % (1 << 23);
            m_prev = int'(ser_clk);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3", "model a_ref", int'(a_ref_div), m_ref[1]);
            chk("R3", "model b_ref", int'(b_ref_div), m_ref[0]);
            chk("R3", "model a_pol", int'(a_pol_inv), m_pol[1]);
            chk("R3", "model b_pol", int'(b_pol_inv), m_pol[0]);
            chk("R3", "model a_presc", int'(a_hi_presc), m_presc[1]);
            chk("R3", "model b_presc", int'(b_hi_presc), m_presc[0]);
            chk("R4", "model a_swal", int'(a_swallow), m_swal[1]);
            chk("R4", "model b_swal", int'(b_swallow), m_swal[0]);
            chk("R4", "model a_prog", int'(a_prog), m_prog[1]);
            chk("R4", "model b_prog", int'(b_prog), m_prog[0]);
            chk("R5", "model mon", int'(mon_sel), m_mon);
            chk("R9", "model err", int'(cfg_err), m_err);
        end
    end

    task automatic shift_word(logic [22:0] w);
        for (int i = 22; i >= 0; i--) begin
            ser_data = w[i];
            @(negedge clk);
            ser_clk = 1'b1;
            @(negedge clk);
            ser_clk = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic send_word(logic [22:0] w);
        shift_word(w);
        ser_le = 1'b1;
        repeat (2) @(negedge clk);
        ser_le = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [22:0] ref_word(int code, int ratio, int pol, int presc, int mon);
        return 23'((mon << 18) | (presc << 17) | (pol << 16) | (ratio << 2) | code);
    endfunction

    function automatic logic [22:0] main_word(int code, int swal, int prog);
        return 23'((prog << 9) | (swal << 2) | code);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "a_ref", int'(a_ref_div), 0);
        chk("R8", "b_prog", int'(b_prog), 0);
        chk("R8", "err/mon", int'({cfg_err, mon_sel}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R5: channel A reference word, code 2'b10
        send_word(ref_word(2, 384, 1, 1, 1));
        chk("R3", "a_ref_div", int'(a_ref_div), 384);
        chk("R3", "a_pol/presc", int'({a_pol_inv, a_hi_presc}), 3);
        chk("R5", "mon_sel set", int'(mon_sel), 1);
        chk("R7", "b_ref untouched", int'(b_ref_div), 0);

        // R4: channel A main word, code 2'b11
        send_word(main_word(3, 7, 291));
        chk("R4", "a_swallow", int'(a_swallow), 7);
        chk("R4", "a_prog", int'(a_prog), 291);
        chk("R7", "a_ref kept", int'(a_ref_div), 384);

        // R2 R10 R5: channel B reference code 2'b00, ratio 16383, bit 18 ignored
        send_word(ref_word(0, 16383, 0, 1, 0));
        send_word(ref_word(0, 16383, 0, 1, 1));
        chk("R10", "b_ref max", int'(b_ref_div), 16383);
        chk("R2", "b_presc", int'(b_hi_presc), 1);
        chk("R5", "mon from B ignored", int'(mon_sel), 1);

        // R2 R10: channel B main code 2'b01, swallow 0, program 5
        send_word(main_word(1, 0, 5));
        chk("R10", "b_prog min", int'(b_prog), 5);
        chk("R2", "b_swallow", int'(b_swallow), 0);
        chk("R7", "a_prog kept", int'(a_prog), 291);

        // R1 R6: shifting without the strobe changes nothing
        shift_word(main_word(3, 100, 2047));
        chk("R6", "no strobe a_prog", int'(a_prog), 291);
        ser_le = 1'b1;
        repeat (2) @(negedge clk);
        ser_le = 1'b0;
        @(negedge clk);
        chk("R1", "late strobe a_prog", int'(a_prog), 2047);
        chk("R10", "a_prog max", int'(a_prog), 2047);
        chk("R1", "late strobe a_swal", int'(a_swallow), 100);
        chk("R9", "no error yet", int'(cfg_err), 0);

        // R9: out-of-range words rejected, error sticky
        send_word(ref_word(2, 4, 0, 0, 0));
        chk("R9", "a_ref kept", int'(a_ref_div), 384);
        chk("R9", "mon kept", int'(mon_sel), 1);
        chk("R9", "err set", int'(cfg_err), 1);
        send_word(main_word(1, 9, 4));
        chk("R9", "b_prog kept", int'(b_prog), 5);
        send_word(ref_word(2, 5, 0, 0, 0));
        chk("R10", "a_ref min", int'(a_ref_div), 5);
        chk("R5", "mon cleared", int'(mon_sel), 0);
        chk("R9", "err sticky", int'(cfg_err), 1);

        // R6: strobe held high while a new word shifts in; latches follow
        ser_le = 1'b1;
        shift_word(main_word(1, 33, 1000));
        ser_le = 1'b0;
        @(negedge clk);
        chk("R6", "level load b_prog", int'(b_prog), 1000);
        chk("R6", "level load b_swal", int'(b_swallow), 33);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule